// File: doc/BRIEF.md
# Peak-current-limited complementary PWM generator

This block drives the two gate signals of one half-bridge leg in a switching DC/DC converter. An up-counting time base sets the switching period. The high-side gate turns on at the start of every period and turns off at a programmed compare point, which sets the maximum on-time. The low-side gate is the complement of the high side, with separate programmable dead times before each turn-on.

A comparator trip input, driven by an external peak-current comparator, can end the high-side pulse early. The input is synchronized, filtered and made polarity-selectable before it is used. A trip only ends the current period's on-time, and switching resumes at the next period. A sticky trip flag records that a trip happened until software clears it. A one-clock start-of-conversion pulse marks each period start for the current-sense converter. When the run enable is low, both gates are held off.

Top module: `pcl_pwm`

## Requirements
- R1: While `run_en` is high, the counter runs from 0 up to `period` (period of at least 1) and then returns to 0, so one period is `period`+1 clocks. `soc` is high for exactly one clock after each counter-zero clock, and gate outputs are registered with the same one-clock latency as `soc`.
- R2: With k the counter value, the high-side drive is on for k < L and off for k >= L. Here L is the active compare value when it is below `period`, so a compare of 0 keeps the high side off.
- R3: When the active compare value is greater than or equal to `period`, L becomes `period` minus `fall_dly`, and is 0 if that difference is negative.
- R4: `cmp_in` is copied into the active compare register only at the clock where the counter returns to zero, or while `run_en` is low. A change in mid-period does not alter the current period.
- R5: `gate_hi` rises `rise_dly` clocks after the high-side drive turns on and falls with no extra delay. `gate_lo` rises `fall_dly` clocks after the drive turns off and falls with no extra delay. The two gates are never high together.
- R6: The trip input passes through a two-flop synchronizer and a 3-sample majority filter. A level held for two or more clocks and applied during the on-time takes `gate_hi` low at the fifth rising edge after it is applied. The low side follows after `fall_dly`. A one-clock pulse is rejected.
- R7: A trip's effect on the gates ends when the counter returns to zero. The next period switches normally if the trip is gone.
- R8: With `trip_pol` = 0 the trip is active high. With `trip_pol` = 1 it is active low.
- R9: `trip_flag` sets together with the trip's effect on `gate_hi`. It stays set after the trip input is released and across periods until a `flag_clr` pulse clears it at the next edge. A pending trip takes priority over the clear.
- R10: When `run_en` is low, `gate_hi`, `gate_lo` and `soc` are low from the next edge and the counter is held at 0. Re-enabling gives an `soc` pulse after the first edge.
- R11: During reset, `gate_hi`, `gate_lo`, `soc` and `trip_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables switching; low forces both gates off |
| period | input | CW | Counter terminal value |
| cmp_in | input | CW | Shadow compare value (maximum on-time) |
| rise_dly | input | DW | Dead time before high-side turn-on, in clocks |
| fall_dly | input | DW | Dead time before low-side turn-on, in clocks |
| trip_in | input | 1 | Raw peak-current trip input |
| trip_pol | input | 1 | 1 selects active-low trip input |
| flag_clr | input | 1 | Clears the sticky trip flag |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| soc | output | 1 | Start-of-conversion pulse, one per period |
| trip_flag | output | 1 | Sticky trip flag |

## Verification
The main function is swept over three periods, every compare value from 0 to two above the period, and every pairing of four rising and four falling dead times. This separates the plain compare case, the zero-compare case, the capped case and the case where a dead time swallows the whole pulse. The trip path is tried with a held level, a one-clock glitch and the inverted polarity, which tells filtering apart from latching and tells the per-period release apart from the sticky flag. A mid-period compare change and a run-enable drop show shadow loading and forced-off behaviour separately from normal switching.

// File: rtl/pcl_pwm.sv
module pcl_pwm #(
  parameter int CW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] cmp_in,
  input  logic [DW-1:0] rise_dly,
  input  logic [DW-1:0] fall_dly,
  input  logic          trip_in,
  input  logic          trip_pol,
  input  logic          flag_clr,
  output logic          gate_hi,
  output logic          gate_lo,
  output logic          soc,
  output logic          trip_flag
);
  localparam int AW   = DW + 1;
  localparam int PADW = CW + 1 - DW;

  logic [CW-1:0] cnt, cmp_act, lim;
  logic [CW:0]   cap_w;
  logic          wrap, on_win, hi_raw, trip_q, trip_cyc, pa;
  logic          s1, s2;
  logic [2:0]    hist;
  logic [AW-1:0] age, cur_age;

  assign wrap   = cnt >= period;
  assign cap_w  = {1'b0, period} - {{PADW{1'b0}}, fall_dly};
  assign lim    = (cmp_act >= period) ? (cap_w[CW] ? '0 : cap_w[CW-1:0]) : cmp_act;
  assign on_win = run_en && (cnt < lim);
  assign trip_q = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
  assign hi_raw = on_win && !trip_cyc && !trip_q;

  assign cur_age = (hi_raw != pa) ? AW'(1) : ((&age) ? age : age + AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp_act <= '0;
    end else begin
      if (!run_en || wrap) cnt <= '0;
      else                 cnt <= cnt + CW'(1);
      if (!run_en || wrap) cmp_act <= cmp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      hist <= '0;
    end else begin
      s1   <= trip_in ^ trip_pol;
      s2   <= s1;
      hist <= {hist[1:0], s2};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                trip_cyc <= 1'b0;
    else if (!run_en || wrap)  trip_cyc <= 1'b0;
    else if (trip_q && on_win) trip_cyc <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trip_flag <= 1'b0;
    else if (trip_q)   trip_flag <= 1'b1;
    else if (flag_clr) trip_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa      <= 1'b0;
      age     <= '1;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      soc     <= 1'b0;
    end else begin
      pa      <= hi_raw;
      age     <= cur_age;
      gate_hi <= hi_raw && (cur_age > {1'b0, rise_dly});
      gate_lo <= run_en && !hi_raw && (cur_age > {1'b0, fall_dly});
      soc     <= run_en && (cnt == '0);
    end
  end
endmodule

// File: rtl/pcl_pwm_chk.sv
module pcl_pwm_chk #(
  parameter int CW = 8,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic [CW-1:0] period,
  input logic [DW-1:0] fall_dly,
  input logic          flag_clr,
  input logic          gate_hi,
  input logic          gate_lo,
  input logic          soc,
  input logic          trip_flag,
  input logic [CW-1:0] cnt
);
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  p_dead_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && fall_dly != '0) |=> !gate_lo);

  p_run_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!gate_hi && !gate_lo && !soc));

  p_soc_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (soc && run_en && period != '0) |=> !soc);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag && !flag_clr) |=> trip_flag);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt != '0) |=> (cnt == '0 || cnt == $past(cnt) + CW'(1)));
endmodule

bind pcl_pwm pcl_pwm_chk #(.CW(CW), .DW(DW)) u_chk (.*);

// File: tb/test_pcl_pwm.sv
module test_pcl_pwm;
  localparam int CLK_P = 10;
  localparam int CW = 8;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n, run_en, trip_in, trip_pol, flag_clr;
  logic [CW-1:0] period, cmp_in;
  logic [DW-1:0] rise_dly, fall_dly;
  logic gate_hi, gate_lo, soc, trip_flag;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pcl_pwm #(.CW(CW), .DW(DW)) i_pcl_pwm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period(period), .cmp_in(cmp_in),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .trip_in(trip_in), .trip_pol(trip_pol),
    .flag_clr(flag_clr), .gate_hi(gate_hi), .gate_lo(gate_lo), .soc(soc),
    .trip_flag(trip_flag));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int lim_of(int p, int c, int f);
    if (c >= p) return (p - f < 0) ? 0 : p - f;
    return c;
  endfunction

  task automatic chk_point(int k, int l, int r, int f, string th);
    int eh, el;
    eh = (k >= r && k < l) ? 1 : 0;
    el = (l == 0) ? 1 : ((k >= l + f) ? 1 : 0);
    chk(th, "gate_hi", int'(gate_hi), eh);
    chk("R5", "gate_lo", int'(gate_lo), el);
    chk("R1", "soc", int'(soc), (k == 0) ? 1 : 0);
  endtask

  task automatic align();
    do @(negedge clk); while (!soc);
  endtask

  task automatic setup(int p, int c, int r, int f);
    period = CW'(p); cmp_in = CW'(c); rise_dly = DW'(r); fall_dly = DW'(f);
    repeat (3 * (p + 1) + 2) @(negedge clk);
    align();
  endtask

  task automatic check_period(int p, int l, int r, int f, string th, int eflag);
    for (int k = 0; k <= p; k++) begin
      chk_point(k, l, r, f, th);
      chk("R9", "trip_flag", int'(trip_flag), eflag);
      @(negedge clk);
    end
  endtask

  task automatic trip_period(int p, int r, int f, int act_lvl, string tag);
    for (int k = 0; k <= p; k++) begin
      chk_point(k, 7, r, f, tag);
      chk("R9", "trip_flag", int'(trip_flag), (k >= 7) ? 1 : 0);
      if (k == 2) trip_in = act_lvl[0];
      if (k == 5) trip_in = ~act_lvl[0];
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; trip_in = 1'b0; trip_pol = 1'b0; flag_clr = 1'b0;
    period = 8'd9; cmp_in = 8'd4; rise_dly = '0; fall_dly = '0;
    repeat (3) @(negedge clk);
    chk("R11", "gate_hi", int'(gate_hi), 0);
    chk("R11", "gate_lo", int'(gate_lo), 0);
    chk("R11", "soc", int'(soc), 0);
    chk("R11", "trip_flag", int'(trip_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_en = 1'b1;

    // R1 R2 R3 R5: sweep of period, compare and both dead times
    foreach (period[i]) begin end
    for (int pi = 0; pi < 3; pi++) begin
      int p;
      p = (pi == 0) ? 3 : (pi == 1) ? 8 : 13;
      for (int c = 0; c <= p + 2; c++)
        for (int r = 0; r < 4; r++)
          for (int f = 0; f < 4; f++) begin
            setup(p, c, r, f);
            check_period(p, lim_of(p, c, f), r, f, (c >= p) ? "R3" : "R2", 0);
          end
    end

    // R4: shadow compare loads only at period start
    setup(9, 3, 0, 0);
    for (int k = 0; k <= 9; k++) begin
      chk_point(k, 3, 0, 0, "R4");
      if (k == 1) cmp_in = 8'd6;
      @(negedge clk);
    end
    check_period(9, 6, 0, 0, "R4", 0);

    // R6 R7 R9: held trip, release at next period, sticky flag
    setup(20, 15, 1, 2);
    trip_period(20, 1, 2, 1, "R6");
    check_period(20, 15, 1, 2, "R7", 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9", "trip_flag after clear", int'(trip_flag), 0);

    // R6: one-clock glitch is rejected
    align();
    for (int k = 0; k <= 20; k++) begin
      chk_point(k, 15, 1, 2, "R6");
      chk("R6", "trip_flag glitch", int'(trip_flag), 0);
      if (k == 2) trip_in = 1'b1;
      if (k == 3) trip_in = 1'b0;
      @(negedge clk);
    end

    // R8: inverted polarity
    trip_pol = 1'b1; trip_in = 1'b1;
    align();
    check_period(20, 15, 1, 2, "R8", 0);
    trip_period(20, 1, 2, 0, "R8");
    check_period(20, 15, 1, 2, "R8", 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    trip_pol = 1'b0; trip_in = 1'b0;
    chk("R9", "trip_flag after clear", int'(trip_flag), 0);

    // R10: run low forces gates off
    align();
    repeat (4) @(negedge clk);
    run_en = 1'b0;
    trip_in = 1'b1;
    for (int k = 0; k < 42; k++) begin
      @(negedge clk);
      chk("R10", "gate_hi", int'(gate_hi), 0);
      chk("R10", "gate_lo", int'(gate_lo), 0);
      chk("R10", "soc", int'(soc), 0);
    end
    trip_in = 1'b0;
    repeat (6) @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    chk("R10", "soc after restart", int'(soc), 1);

    summary();
  end
endmodule